// File: doc/BRIEF.md
# Byte-to-Word Link Assembler

This block sits behind a byte-wide link receiver. It gathers consecutive data bytes into a 32-bit word. The receiver presents an 8-bit data bus with a data strobe, and a 4-bit command bus with a command strobe. Every strobe of either kind advances a one-hot ring sequencer by one position. Only data strobes write a byte, and the byte goes into the capture register that the ring selects.

When the ring reaches its last position, a transfer is marked pending. On the next clock the whole capture bank is copied at once into a separate output bank, and `word_valid` pulses for one clock. Because the two banks are separate, the published word stays steady while the following word is being gathered.

A command of all zeros is the sync code. The link sends it in every idle byte time. Sync returns the ring to its parked state, so the next data byte lands in lane 0 and a new block always starts on a word boundary.

Top module: `link_word_assembler`

## Requirements
- R1: A synchronous active-high reset clears `word_out` to 0 and `word_valid` to 0. After reset, the first data byte is placed in lane 0, even if reset arrived part way through a word.
- R2: Bytes are placed in arrival order. The first byte of a word goes to `word_out[7:0]`, the second to [15:8], the third to [23:16] and the fourth to [31:24].
- R3: `word_valid` goes high for exactly one clock. That clock is the one that follows the edge on which the fourth byte position was taken, and `word_out` carries the new word in that same clock.
- R4: `word_out` keeps its value between updates. It does not change while the next word is being collected.
- R5: A command strobe with `cmd_in` equal to 4'b0000 is a sync. It parks the ring, so the next data byte goes to lane 0. The partial word is dropped and no word is emitted.
- R6: Any number of back-to-back syncs leave the ring parked and raise no `word_valid`.
- R7: A command strobe with a nonzero code advances the ring by one lane but writes no byte. The skipped lane keeps whatever byte it held before.
- R8: When data strobes arrive on every clock, successive words come out complete and in order, with no byte lost at a word boundary.
- R9: When a sync and a data strobe arrive in the same clock, the sync wins. The byte is discarded and the ring is parked.
- R10: Clocks with no strobe change neither the ring position nor the capture registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Data byte from the link receiver |
| data_stb | input | 1 | Data strobe; `data_in` is valid in this clock |
| cmd_in | input | 4 | Command code from the link receiver |
| cmd_stb | input | 1 | Command strobe; `cmd_in` is valid in this clock |
| word_out | output | 32 | Last complete word, byte 0 in the low bits |
| word_valid | output | 1 | One-clock pulse when `word_out` is updated |

## Verification
Two functions can fall in the same clock: the bulk copy of a finished word into the output bank, and the capture of byte 0 of the next word into the capture bank. They coincide whenever data strobes run on every clock. The bench provokes this with twelve consecutive strobes and checks that all three words come out intact and in order. A second collision, a sync and a data strobe in the same clock, is judged by the word formed from the four bytes that follow it.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
  // Command code that marks an idle/sync byte time
  localparam int unsigned SYNC_CODE = 0;

  // Bit offset of lane idx inside a word of lanes, each bw bits wide
  function automatic int unsigned lane_lsb(input int unsigned idx, input int unsigned bw);
    return idx * bw;
  endfunction

  // Next state of a one-hot ring: shift left, inject when the lower stages are idle
  function automatic logic [3:0] ring_step4(input logic [3:0] r);
    return {r[2:0], ~|r[2:0]};
  endfunction
endpackage

// File: rtl/lwa_sequencer.sv
module lwa_sequencer #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             realign,
  output logic [LANES-1:0] lane_sel,
  output logic             xfer
);
  logic [LANES-1:0] ring;
  logic [LANES-1:0] ring_nxt;
  logic             pend;

  // shift toward the top stage; a NOR of all but the last stage refills stage 0
  assign ring_nxt = {ring[LANES-2:0], ~|ring[LANES-2:0]};
  assign lane_sel = ring_nxt;
  assign xfer     = pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring <= '0;
      pend <= 1'b0;
    end else begin
      if (realign)   ring <= '0;
      else if (step) ring <= ring_nxt;
      pend <= step & ~realign & ring_nxt[LANES-1];
    end
  end

  // R5
  ring_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(ring));
  // R5
  realign_park_chk: assert property (@(posedge clk) disable iff (rst) realign |=> (ring == '0));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) (!step && !realign) |=> $stable(ring));
  // R3
  pend_single_chk: assert property (@(posedge clk) disable iff (rst) pend |=> !pend);
endmodule

// File: rtl/lwa_capture_bank.sv
module lwa_capture_bank #(
  parameter int unsigned LANES = 4,
  parameter int unsigned BW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [LANES-1:0]    sel,
  input  logic [BW-1:0]       din,
  output logic [LANES*BW-1:0] cap
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned LSB = lwa_pkg::lane_lsb(g, BW);
    always_ff @(posedge clk) begin
      if (rst)                cap[LSB +: BW] <= '0;
      else if (load && sel[g]) cap[LSB +: BW] <= din;
    end
  end

  // R7
  no_load_hold_chk: assert property (@(posedge clk) disable iff (rst) !load |=> $stable(cap));
endmodule

// File: rtl/lwa_output_bank.sv
module lwa_output_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         xfer,
  input  logic [W-1:0] cap,
  output logic [W-1:0] word_out,
  output logic         word_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= xfer;
      if (xfer) word_out <= cap;
    end
  end

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst) !xfer |=> $stable(word_out));
endmodule

// File: rtl/link_word_assembler.sv
module link_word_assembler #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned CMD_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [BYTE_W-1:0]       data_in,
  input  logic                    data_stb,
  input  logic [CMD_W-1:0]        cmd_in,
  input  logic                    cmd_stb,
  output logic [LANES*BYTE_W-1:0] word_out,
  output logic                    word_valid
);
  localparam int unsigned WORD_W = LANES * BYTE_W;

  logic             step;
  logic             realign;
  logic             load;
  logic             xfer;
  logic [LANES-1:0] lane_sel;
  logic [WORD_W-1:0] cap;

  assign step    = data_stb | cmd_stb;
  assign realign = cmd_stb & (cmd_in == CMD_W'(lwa_pkg::SYNC_CODE));
  assign load    = data_stb & ~realign;

  lwa_sequencer #(.LANES(LANES)) u_seq (
    .clk(clk), .rst(rst), .step(step), .realign(realign),
    .lane_sel(lane_sel), .xfer(xfer)
  );

  lwa_capture_bank #(.LANES(LANES), .BW(BYTE_W)) u_cap (
    .clk(clk), .rst(rst), .load(load), .sel(lane_sel), .din(data_in), .cap(cap)
  );

  lwa_output_bank #(.W(WORD_W)) u_out (
    .clk(clk), .rst(rst), .xfer(xfer), .cap(cap),
    .word_out(word_out), .word_valid(word_valid)
  );

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst) word_valid |=> !word_valid);
  // R3
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(word_valid) |-> $past(xfer));
  // R9
  sync_blocks_load_chk: assert property (@(posedge clk) disable iff (rst) realign |-> !load);
endmodule

// File: tb/link_word_assembler_bench.sv
`timescale 1ns/1ps
module link_word_assembler_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  data_in = '0;
  logic        data_stb = 1'b0;
  logic [3:0]  cmd_in = '0;
  logic        cmd_stb = 1'b0;
  logic [31:0] word_out;
  logic        word_valid;

  int checks = 0;
  int errors = 0;
  int nw = 0;
  logic [31:0] words [0:63];
  bit done = 0;

  always #2.5 clk = ~clk;

  link_word_assembler u_link_word_assembler (
    .clk(clk), .rst(rst), .data_in(data_in), .data_stb(data_stb),
    .cmd_in(cmd_in), .cmd_stb(cmd_stb), .word_out(word_out), .word_valid(word_valid)
  );

  always @(negedge clk) begin
    if (!rst && word_valid && nw < 64) begin
      words[nw] = word_out;
      nw++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock of stimulus, starting and ending at a falling edge
  task automatic cyc(input bit ds, input logic [7:0] d, input bit cs, input logic [3:0] c);
    data_stb = ds; data_in = d; cmd_stb = cs; cmd_in = c;
    @(negedge clk);
    data_stb = 0; cmd_stb = 0;
  endtask

  task automatic byte_in(input logic [7:0] b); cyc(1, b, 0, 4'h0); endtask
  task automatic sync_in(); cyc(0, 8'h00, 1, 4'h0); endtask
  task automatic idle(); cyc(0, 8'h00, 0, 4'h0); endtask

  task automatic t_reset();
    rst = 1; idle(); idle(); rst = 0;
    chk(word_out == 0, "R1 word_out", word_out, 0);
    chk(word_valid == 0, "R1 word_valid", {31'b0, word_valid}, 0);
  endtask

  task automatic t_basic();
    byte_in(8'h11); byte_in(8'h22); byte_in(8'h33); byte_in(8'h44);
    chk(word_valid == 0, "R3 not yet", {31'b0, word_valid}, 0);
    idle();
    chk(word_valid == 1, "R3 pulse", {31'b0, word_valid}, 1);
    chk(word_out == 32'h44332211, "R2 order", word_out, 32'h44332211);
    idle();
    chk(word_valid == 0, "R3 one clock", {31'b0, word_valid}, 0);
  endtask

  task automatic t_gaps();
    int n0 = nw;
    byte_in(8'h5A); idle(); idle(); byte_in(8'h6B); idle();
    chk(word_out == 32'h44332211, "R4 hold while collecting", word_out, 32'h44332211);
    byte_in(8'h7C); idle(); idle(); idle(); byte_in(8'h8D); idle(); idle();
    chk(nw == n0 + 1, "R10 word count", nw, n0 + 1);
    chk(word_out == 32'h8D7C6B5A, "R10 gaps keep position", word_out, 32'h8D7C6B5A);
  endtask

  task automatic t_sync();
    int n0 = nw;
    byte_in(8'hE1); byte_in(8'hE2); sync_in();
    byte_in(8'h01); byte_in(8'h02); byte_in(8'h03); byte_in(8'h04); idle(); idle();
    chk(nw == n0 + 1, "R5 one word", nw, n0 + 1);
    chk(word_out == 32'h04030201, "R5 realigned", word_out, 32'h04030201);
  endtask

  task automatic t_many_syncs();
    int n0 = nw;
    for (int i = 0; i < 10; i++) sync_in();
    idle();
    chk(nw == n0, "R6 no word", nw, n0);
    chk(word_out == 32'h04030201, "R6 output held", word_out, 32'h04030201);
  endtask

  task automatic t_cmd_skip();
    byte_in(8'hA0); byte_in(8'hA1); byte_in(8'hA2); byte_in(8'hA3); idle();
    sync_in();
    byte_in(8'hB0); cyc(0, 8'hFF, 1, 4'h5); byte_in(8'hB2); byte_in(8'hB3); idle(); idle();
    chk(word_out == 32'hB3B2A1B0, "R7 cmd advances, no write", word_out, 32'hB3B2A1B0);
  endtask

  task automatic t_back_to_back();
    int n0;
    sync_in(); idle(); idle();
    n0 = nw;
    for (int i = 0; i < 12; i++) byte_in(8'(8'h20 + i));
    idle(); idle();
    chk(nw == n0 + 3, "R8 three words", nw, n0 + 3);
    chk(words[n0]     == 32'h23222120, "R8 word0", words[n0],     32'h23222120);
    chk(words[n0 + 1] == 32'h27262524, "R8 word1", words[n0 + 1], 32'h27262524);
    chk(words[n0 + 2] == 32'h2B2A2928, "R8 word2", words[n0 + 2], 32'h2B2A2928);
  endtask

  task automatic t_sync_collide();
    byte_in(8'hC0); cyc(1, 8'hDD, 1, 4'h0);
    byte_in(8'hC1); byte_in(8'hC2); byte_in(8'hC3); byte_in(8'hC4); idle(); idle();
    chk(word_out == 32'hC4C3C2C1, "R9 sync wins", word_out, 32'hC4C3C2C1);
  endtask

  task automatic t_reset_mid();
    byte_in(8'h91); byte_in(8'h92);
    rst = 1; idle(); rst = 0;
    chk(word_out == 0, "R1 cleared mid-word", word_out, 0);
    byte_in(8'h71); byte_in(8'h72); byte_in(8'h73); byte_in(8'h74); idle(); idle();
    chk(word_out == 32'h74737271, "R1 lane 0 after reset", word_out, 32'h74737271);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_gaps();
    t_sync();
    t_many_syncs();
    t_cmd_skip();
    t_back_to_back();
    t_sync_collide();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule